// File: doc/BRIEF.md
# I2C Bus Master with Byte Register Interface

This block is an I2C bus master controlled by software through five byte-wide registers on a simple peripheral bus. Software puts a 7-bit target address and a direction bit into the data register, then writes the status register with the start flag set. The block issues START and sends that byte. It then moves bytes one at a time, sent or received, each with its acknowledge slot. After every byte it stops with SCL held low until software acts. A write to the status register with the start flag clear ends the transfer with STOP.

The handshake runs on a sticky interrupt-pending flag in the control register. Each finished byte sets the flag and raises the interrupt line, but only when interrupts are enabled. Software touches the data register, which means writing the next byte when sending or reading the received byte when receiving. It then clears the flag, and that releases the next byte. SCL comes from the system clock through a divider; its quarter period is the `QDIV` parameter. Both bus lines are open-drain. The block only ever pulls a line low or lets it go.

Top module: `i2cm_top`

## Requirements
- R1: After reset the register reads are: control (offset 0x00) = 0x00, status (0x04) = 0x00, own address (0x08) = 0xFF, data (0x0C) = 0xFF, line control (0x10) = 0x00, and the interrupt output is low.
- R2: Reads at an offset that is not word-aligned, or that is 0x14 or above, return 0x00, and writes there change nothing. The line control register at 0x10 stores whatever is written to it and reads it back.
- R3: Control bit 4 is the pending flag, bit 5 enables the interrupt and bit 7 enables ACK generation. Writing 1 to bit 4 never sets the flag. Writing 0 to bit 4 while the flag is set clears it and lowers the interrupt.
- R4: The status register holds the mode in bits 7:6 (2 = receive master, 3 = transmit master), busy in bit 5, output enable in bit 4 and the no-acknowledge flag in bit 0. A status write in a master mode with bits 5 and 4 set does three things: it clears bit 0, it sets busy, and it issues START followed by the data register byte as the address byte, sent MSB first.
- R5: After each byte, pending is set and the interrupt is raised only when the interrupt is enabled. A target NACK sets status bit 0 only when ACK generation is enabled.
- R6: While pending is set, no byte moves. Clearing pending after a data register access starts the next byte in the current mode. Clearing pending with no such access leaves pending set and the interrupt high.
- R7: In transmit master mode, a data register write while busy and not pending sends that byte at once.
- R8: A START in receive master mode sends the address byte and then receives one byte into the data register before raising pending. On the ninth clock of a received byte the master drives ACK (SDA low) when ACK generation is enabled and NACK otherwise.
- R9: A master-mode status write with bit 5 clear issues STOP. Busy clears at once if nothing is pending. Otherwise busy stays set until pending is cleared.
- R10: A status write with bit 4 clear aborts the transfer: busy clears, the interrupt drops and both bus lines are released.
- R11: Data register writes are accepted only while output enable is set. Own address register writes are accepted only while output enable is clear.
- R12: SDA changes while SCL is released only for START and STOP, and the lines are only ever pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register byte offset |
| regWr | input | 1 | Register write strobe, one cycle |
| regRd | input | 1 | Register read strobe, one cycle |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from regAddr |
| irq | output | 1 | Level interrupt |
| sdaIn | input | 1 | Sampled SDA bus level |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that software issues no register access while a byte is moving on the bus. They also assume that reads and writes never fall in the same cycle and that no target stretches the clock. The bench waits for the interrupt, or for a fixed span longer than one byte when interrupts are disabled, before each new access. The target model on the bus changes SDA only after SCL falls, and it releases SDA after a master NACK so that STOP can form.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REG_AW = 5;
  localparam logic [1:0] MODE_MRX = 2'b10;
  localparam logic [1:0] MODE_MTX = 2'b11;

  typedef struct packed {
    logic start;
    logic send;
    logic recv;
    logic stop;
    logic abort;
  } eng_cmd_t;
endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              irq,
  output eng_cmd_t          cmd,
  output logic [7:0]        txByte,
  output logic              ackGen,
  output logic              rxMode,
  input  logic              byteDone,
  input  logic              doneNack,
  input  logic [7:0]        doneRx,
  input  logic              doneWasRx
);
  logic [7:0] con, stat, ownAddr, ds, lc;
  logic sclFree, stopSeen, irqQ;
  eng_cmd_t cmdQ;

  logic [2:0] idx;
  logic hit, wrCon, wrStat, wrOwn, wrDs, wrLc, rdDs;
  logic [1:0] mode;

  assign idx    = regAddr[4:2];
  assign hit    = (regAddr[1:0] == 2'b00) && (idx <= 3'd4);
  assign wrCon  = regWr && hit && idx == 3'd0;
  assign wrStat = regWr && hit && idx == 3'd1;
  assign wrOwn  = regWr && hit && idx == 3'd2;
  assign wrDs   = regWr && hit && idx == 3'd3;
  assign wrLc   = regWr && hit && idx == 3'd4;
  assign rdDs   = regRd && hit && idx == 3'd3;
  assign mode   = stat[7:6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      con <= 8'h00; stat <= 8'h00; ownAddr <= 8'hFF; ds <= 8'hFF; lc <= 8'h00;
      sclFree <= 1'b1; stopSeen <= 1'b0; irqQ <= 1'b0; cmdQ <= '0;
    end else begin
      cmdQ <= '0;
      if (byteDone) begin
        if (doneWasRx) ds <= doneRx;
        stat[0] <= doneNack & con[7];
        if (con[5]) begin con[4] <= 1'b1; irqQ <= 1'b1; end
      end
      if (wrCon) begin
        con <= {regWdata[7:5], con[4], regWdata[3:0]};
        if (con[4] && !regWdata[4]) begin
          con[4] <= 1'b0;
          irqQ   <= 1'b0;
          if (!regWdata[5]) begin
            stat[5] <= 1'b0; stopSeen <= 1'b0;
          end else if (stat[5]) begin
            if (stopSeen) begin
              stat[5] <= 1'b0; stopSeen <= 1'b0;
            end else if (sclFree) begin
              sclFree <= 1'b0;
              if (mode == MODE_MTX) cmdQ.send <= 1'b1;
              else if (mode == MODE_MRX) cmdQ.recv <= 1'b1;
            end else begin
              con[4] <= 1'b1; irqQ <= 1'b1;
            end
          end
        end
      end
      if (wrStat) begin
        stat <= {regWdata[7:6], stat[5], regWdata[4:0]};
        if (!regWdata[4]) begin
          stat[5] <= 1'b0; sclFree <= 1'b1; irqQ <= 1'b0; stopSeen <= 1'b0;
          cmdQ.abort <= 1'b1;
        end else if (regWdata[7]) begin
          if (regWdata[5]) begin
            stat[5] <= 1'b1; stat[0] <= 1'b0; sclFree <= 1'b0; stopSeen <= 1'b0;
            cmdQ.start <= 1'b1;
          end else begin
            cmdQ.stop <= 1'b1;
            sclFree   <= 1'b1;
            if (!con[4]) stat[5] <= 1'b0;
            else if (stat[5]) stopSeen <= 1'b1;
          end
        end
      end
      if (wrOwn && !stat[4]) ownAddr <= regWdata;
      if (wrDs && stat[4]) begin
        ds <= regWdata;
        sclFree <= 1'b1;
        if (mode == MODE_MTX && stat[5] && !con[4]) begin
          cmdQ.send <= 1'b1; sclFree <= 1'b0;
        end
      end
      if (wrLc) lc <= regWdata;
      if (rdDs) begin
        sclFree <= 1'b1;
        if (mode == MODE_MRX && stat[5] && !con[4]) begin
          cmdQ.recv <= 1'b1; sclFree <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    regRdata = 8'h00;
    if (hit) begin
      case (idx)
        3'd0:    regRdata = con;
        3'd1:    regRdata = stat;
        3'd2:    regRdata = ownAddr;
        3'd3:    regRdata = ds;
        3'd4:    regRdata = lc;
        default: regRdata = 8'h00;
      endcase
    end
  end

  assign irq    = irqQ;
  assign cmd    = cmdQ;
  assign txByte = ds;
  assign ackGen = con[7];
  assign rxMode = (mode == MODE_MRX);

  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> con[5]);
  // R3
  pend_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(con[4]) |-> ($past(byteDone) || $past(wrCon)));
  // R4
  busy_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat[5]) |-> $past(wrStat && regWdata[5]));
  // R10
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrStat && !regWdata[4]) |-> (!irqQ && !stat[5]));
  // R11
  own_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stat[4]) |-> $stable(ownAddr));
endmodule

// File: rtl/i2cm_shift.sv
module i2cm_shift
  import i2cm_pkg::*;
#(
  parameter int QDIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  eng_cmd_t   cmd,
  input  logic [7:0] txByte,
  input  logic       ackGen,
  input  logic       rxMode,
  input  logic       sdaIn,
  output logic       sclDrvLow,
  output logic       sdaDrvLow,
  output logic       byteDone,
  output logic       doneNack,
  output logic [7:0] doneRx,
  output logic       doneWasRx
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  typedef enum logic [2:0] {S_FREE, S_HOLD, S_START, S_BIT, S_STOP} state_t;
  state_t state;
  logic [CW-1:0] qCnt;
  logic [1:0] qPh;
  logic [3:0] bitIdx;
  logic [7:0] shreg;
  logic isRx, chain, nackR, sclLow, sdaLow, tick;

  assign tick = (qCnt == CW'(QDIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_FREE; qCnt <= '0; qPh <= 2'd0; bitIdx <= 4'd0; shreg <= 8'h00;
      isRx <= 1'b0; chain <= 1'b0; nackR <= 1'b0; sclLow <= 1'b0; sdaLow <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (cmd.abort) begin
        state <= S_FREE; sclLow <= 1'b0; sdaLow <= 1'b0;
      end else begin
        case (state)
          S_FREE, S_HOLD: begin
            qCnt <= '0; qPh <= 2'd0; bitIdx <= 4'd0;
            if (cmd.start) begin
              state <= S_START; shreg <= txByte; chain <= rxMode; isRx <= 1'b0;
            end else if (state == S_HOLD && cmd.send) begin
              state <= S_BIT; shreg <= txByte; isRx <= 1'b0; chain <= 1'b0;
            end else if (state == S_HOLD && cmd.recv) begin
              state <= S_BIT; isRx <= 1'b1; chain <= 1'b0;
            end else if (state == S_HOLD && cmd.stop) begin
              state <= S_STOP;
            end
          end
          default: begin
            if (!tick) begin
              qCnt <= qCnt + CW'(1);
            end else begin
              qCnt <= '0;
              qPh  <= qPh + 2'd1;
              if (state == S_START) begin
                case (qPh)
                  2'd0: sdaLow <= 1'b0;
                  2'd1: sclLow <= 1'b0;
                  2'd2: sdaLow <= 1'b1;
                  default: begin sclLow <= 1'b1; state <= S_BIT; bitIdx <= 4'd0; end
                endcase
              end else if (state == S_STOP) begin
                case (qPh)
                  2'd0: sdaLow <= 1'b1;
                  2'd1: sclLow <= 1'b0;
                  2'd2: sdaLow <= 1'b0;
                  default: state <= S_FREE;
                endcase
              end else begin
                case (qPh)
                  2'd0: begin
                    if (bitIdx < 4'd8) sdaLow <= isRx ? 1'b0 : !shreg[7];
                    else sdaLow <= isRx ? ackGen : 1'b0;
                  end
                  2'd1: sclLow <= 1'b0;
                  2'd2: begin
                    if (bitIdx < 4'd8) shreg <= {shreg[6:0], isRx ? sdaIn : 1'b0};
                    else nackR <= isRx ? 1'b0 : sdaIn;
                  end
                  default: begin
                    sclLow <= 1'b1;
                    if (bitIdx == 4'd8) begin
                      bitIdx <= 4'd0;
                      chain  <= 1'b0;
                      if (chain && !isRx && (!nackR || !ackGen)) isRx <= 1'b1;
                      else begin state <= S_HOLD; byteDone <= 1'b1; end
                    end else begin
                      bitIdx <= bitIdx + 4'd1;
                    end
                  end
                endcase
              end
            end
          end
        endcase
      end
    end
  end

  assign sclDrvLow = sclLow;
  assign sdaDrvLow = sdaLow;
  assign doneNack  = nackR;
  assign doneRx    = shreg;
  assign doneWasRx = isRx;

  // R12
  sda_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclLow && !$past(sclLow) && !$stable(sdaLow)) |->
      ($past(state) == S_START || $past(state) == S_STOP || $past(cmd.abort)));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);
  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && $past(state == S_HOLD)) |-> (sclLow && $stable(sclLow)));
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
  import i2cm_pkg::*;
#(
  parameter int QDIV = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  input  logic       sdaIn,
  output logic       sclDrvLow,
  output logic       sdaDrvLow
);
  eng_cmd_t cmd;
  logic [7:0] txByte, doneRx;
  logic ackGen, rxMode, byteDone, doneNack, doneWasRx;

  i2cm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .cmd(cmd),
    .txByte(txByte), .ackGen(ackGen), .rxMode(rxMode), .byteDone(byteDone),
    .doneNack(doneNack), .doneRx(doneRx), .doneWasRx(doneWasRx)
  );

  i2cm_shift #(.QDIV(QDIV)) uShift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txByte(txByte), .ackGen(ackGen),
    .rxMode(rxMode), .sdaIn(sdaIn), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .byteDone(byteDone), .doneNack(doneNack), .doneRx(doneRx), .doneWasRx(doneWasRx)
  );
endmodule

// File: tb/i2cm_top_test.sv
module i2cm_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic irq, sclDrvLow, sdaDrvLow;
  logic slvSdaLow = 1'b0;
  logic sclBus, sdaBus;

  assign sclBus = !sclDrvLow;
  assign sdaBus = !(sdaDrvLow || slvSdaLow);

  i2cm_top #(.QDIV(QD)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sdaIn(sdaBus),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit mdlIntEn = 1'b0;
  bit done = 1'b0;

  // behavioural target on the bus
  logic [7:0] gotBytes[$];
  bit mAck[$];
  logic [7:0] rdBytes[$];
  int startCnt = 0, stopCnt = 0;
  bit slvNack = 1'b0;
  logic prevScl = 1'b1, prevSda = 1'b1;
  int bitCnt = 0;
  bit isAddr = 1'b0, rdMode = 1'b0, firstFall = 1'b0, lastAck = 1'b0;
  logic [7:0] shIn = '0, rdCur = '0;

  always @(sclBus, sdaBus) begin
    if (sclBus && prevScl && !sdaBus && prevSda) begin
      startCnt++; bitCnt = 0; isAddr = 1'b1; rdMode = 1'b0; firstFall = 1'b1; slvSdaLow = 1'b0;
    end else if (sclBus && prevScl && sdaBus && !prevSda) begin
      stopCnt++; slvSdaLow = 1'b0;
    end else if (sclBus && !prevScl) begin
      if (bitCnt < 8) shIn = {shIn[6:0], sdaBus};
      else if (rdMode && !isAddr) begin lastAck = !sdaBus; mAck.push_back(!sdaBus); end
    end else if (!sclBus && prevScl) begin
      if (firstFall) firstFall = 1'b0;
      else if (bitCnt == 7) begin
        gotBytes.push_back(shIn);
        if (isAddr) rdMode = shIn[0];
        bitCnt = 8;
        slvSdaLow = (isAddr || !rdMode) ? !slvNack : 1'b0;
      end else if (bitCnt == 8) begin
        bitCnt = 0;
        slvSdaLow = 1'b0;
        if (rdMode && (isAddr ? !slvNack : lastAck)) begin
          rdCur = (rdBytes.size() > 0) ? rdBytes.pop_front() : 8'hFF;
          slvSdaLow = !rdCur[7];
        end
        isAddr = 1'b0;
      end else begin
        bitCnt++;
        if (rdMode && !isAddr) slvSdaLow = !rdCur[7-bitCnt];
      end
    end
    prevScl = sclBus; prevSda = sdaBus;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    if (a == 5'h00) mdlIntEn = d[5];
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic rdChk(string req, logic [4:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic waitIrq(string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk(req, irq, 1);
  endtask

  task automatic waitStop(string req, int n);
    int k = 0;
    while (stopCnt < n && k < 3000) begin @(negedge clk); k++; end
    chk(req, stopCnt, n);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // per-clock comparison of the interrupt against the modelled enable (R5)
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN) begin
      checks++;
      if (irq && !mdlIntEn) begin
        errors++;
        $display("FAIL R5 irq actual=%0h expected=%0h", irq, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finishRun();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rdChk("R1 con", 5'h00, 8'h00);
    rdChk("R1 stat", 5'h04, 8'h00);
    rdChk("R1 own", 5'h08, 8'hFF);
    rdChk("R1 ds", 5'h0C, 8'hFF);
    rdChk("R1 lc", 5'h10, 8'h00);
    chk("R1 irq", irq, 0);
    // R2 decode
    wr(5'h14, 8'h55);
    wr(5'h11, 8'h66);
    rdChk("R2 unmapped", 5'h14, 8'h00);
    rdChk("R2 unaligned", 5'h02, 8'h00);
    rdChk("R2 lc untouched", 5'h10, 8'h00);
    wr(5'h10, 8'hA5);
    rdChk("R2 lc stored", 5'h10, 8'hA5);
    // R11 own address writable while output disabled
    wr(5'h08, 8'h3C);
    rdChk("R11 own write", 5'h08, 8'h3C);
    // R3 writing 1 to pending does nothing
    wr(5'h00, 8'hB0);
    rdChk("R3 no set", 5'h00, 8'hA0);
    // transmit: address byte
    wr(5'h04, 8'hD0);
    rdChk("R4 stat mtx", 5'h04, 8'hD0);
    wr(5'h08, 8'h77);
    rdChk("R11 own locked", 5'h08, 8'h3C);
    wr(5'h0C, 8'hA4);
    wr(5'h04, 8'hF0);
    waitIrq("R4 irq");
    chk("R4 start seen", startCnt, 1);
    chk("R4 addr byte", gotBytes.size() > 0 ? gotBytes[0] : 0, 8'hA4);
    rdChk("R4 stat busy", 5'h04, 8'hF0);
    rdChk("R5 pending", 5'h00, 8'hB0);
    // R6 stall while pending, continue after data write plus clear
    wr(5'h0C, 8'h5A);
    idle(300);
    chk("R6 stalled", gotBytes.size(), 1);
    wr(5'h00, 8'hA0);
    waitIrq("R6 irq");
    chk("R6 byte", gotBytes.size() > 1 ? gotBytes[1] : 0, 8'h5A);
    // R5 NACK with ACK generation enabled
    slvNack = 1'b1;
    wr(5'h0C, 8'h33);
    wr(5'h00, 8'hA0);
    waitIrq("R5 irq");
    chk("R5 byte", gotBytes.size() > 2 ? gotBytes[2] : 0, 8'h33);
    rdChk("R5 nack flag", 5'h04, 8'hF1);
    slvNack = 1'b0;
    // R6 clear without data access re-raises pending
    wr(5'h00, 8'hA0);
    idle(4);
    rdChk("R6 re-pend", 5'h00, 8'hB0);
    chk("R6 irq kept", irq, 1);
    chk("R6 no byte", gotBytes.size(), 3);
    // R9 stop while pending
    wr(5'h04, 8'hD0);
    waitStop("R9 stop", 1);
    rdChk("R9 busy held", 5'h04, 8'hF0);
    wr(5'h00, 8'hA0);
    rdChk("R9 busy cleared", 5'h04, 8'hD0);
    chk("R9 irq low", irq, 0);
    // R8 receive
    rdBytes.push_back(8'h96);
    rdBytes.push_back(8'h3C);
    wr(5'h04, 8'h90);
    wr(5'h0C, 8'hA5);
    wr(5'h04, 8'hB0);
    waitIrq("R8 irq");
    rdChk("R8 first byte", 5'h0C, 8'h96);
    chk("R8 addr", gotBytes.size() > 3 ? gotBytes[3] : 0, 8'hA5);
    chk("R8 master ack", mAck.size() > 0 ? mAck[0] : 0, 1);
    rdChk("R8 stat", 5'h04, 8'hB0);
    wr(5'h00, 8'h20);
    waitIrq("R8 irq2");
    rdChk("R8 last byte", 5'h0C, 8'h3C);
    chk("R8 master nack", mAck.size() > 1 ? mAck[1] : 1, 0);
    wr(5'h04, 8'h90);
    waitStop("R9 stop rx", 2);
    wr(5'h00, 8'h20);
    rdChk("R9 rx idle", 5'h04, 8'h90);
    // R7 / R5 interrupts disabled, immediate send
    wr(5'h00, 8'h80);
    wr(5'h04, 8'hD0);
    wr(5'h0C, 8'hA4);
    wr(5'h04, 8'hF0);
    idle(400);
    chk("R5 no irq", irq, 0);
    rdChk("R5 no pend", 5'h00, 8'h80);
    chk("R7 addr", gotBytes.size() > 6 ? gotBytes[6] : 0, 8'hA4);
    wr(5'h0C, 8'h11);
    idle(400);
    chk("R7 data", gotBytes.size() > 7 ? gotBytes[7] : 0, 8'h11);
    wr(5'h04, 8'hD0);
    waitStop("R9 stop nopend", 3);
    rdChk("R9 idle", 5'h04, 8'hD0);
    // R10 abort
    wr(5'h00, 8'hA0);
    wr(5'h0C, 8'hA4);
    wr(5'h04, 8'hF0);
    waitIrq("R10 irq");
    wr(5'h04, 8'h00);
    idle(3);
    chk("R10 irq", irq, 0);
    chk("R10 scl", sclDrvLow, 0);
    chk("R10 sda", sdaDrvLow, 0);
    rdChk("R10 stat", 5'h04, 8'h00);
    // R11 data writes ignored while output disabled
    wr(5'h0C, 8'h12);
    rdChk("R11 ds locked", 5'h0C, 8'hA4);
    wr(5'h08, 8'h99);
    rdChk("R11 own open", 5'h08, 8'h99);
    // R12 lines only pulled low: released level is high
    chk("R12 released", {sclBus, sdaBus}, 2'b11);
    finishRun();
  end
endmodule